// File: doc/BRIEF.md
# Peripheral Interrupt Flag Register

This block collects event pulses from eight peripheral sources into one 8-bit flag register that the CPU can read. Six of the flags are sticky. An event sets the flag, and the flag stays set until software writes a zero to that bit position. The other two flags are not latched. They mirror the serial receive "buffer holds data" status and the serial transmit "buffer empty" status, and software cannot write them.

Each flag is ANDed with its own enable bit. The results are ORed together and the OR is gated by a global enable to form one interrupt request. A flag is set by its event whatever the enables are. Two operating-mode inputs gate flags. The capture/compare flag cannot set while that unit runs in PWM mode. The parallel-port flag exists only in microcontroller mode and is held at zero otherwise.

Top module: `pif_flagreg`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `rd_data` is 0x00 and `irq` is 0.
- R2: Bit positions are fixed. Bit 7 is parallel-port access, bit 6 is A/D done, bit 5 is receive buffer full, bit 4 is transmit buffer empty, bit 3 is synchronous-serial done, bit 2 is capture/compare, bit 1 is timer-2 match and bit 0 is timer-1 overflow. A strobe on a sticky source sets its bit in `rd_data` at the next clock edge, whatever `irq_en` and `gie` are.
- R3: A sticky bit (bit 7, 6, 3, 2, 1 or 0) keeps its value until a write (`wr_en`=1) carries 0 in that bit position. Writing 1 to a sticky bit leaves it unchanged.
- R4: If a set strobe and a write of 0 reach the same sticky bit in the same cycle, the bit is 1 afterwards.
- R5: Bit 5 equals the value `rx_full` had in the previous cycle. Writes do not affect it.
- R6: Bit 4 equals the value `tx_empty` had in the previous cycle. Writes do not affect it.
- R7: Bit 2 sets on `ccp_capture_evt` or `ccp_compare_evt`, but never while `ccp_pwm_mode` is 1.
- R8: When `mcu_mode` is 0, bit 7 is 0 from the next cycle on, and strobes on `pport_evt` have no effect.
- R9: `irq` equals `gie` AND the OR over all bits of (`rd_data` AND `irq_en`), in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Write data; 0 clears a sticky bit |
| rd_data | output | 8 | Current flag bits |
| pport_evt | input | 1 | Parallel-port access strobe |
| adc_evt | input | 1 | A/D conversion done strobe |
| ssp_evt | input | 1 | Synchronous-serial transfer done strobe |
| ccp_capture_evt | input | 1 | Capture event strobe |
| ccp_compare_evt | input | 1 | Compare match strobe |
| tmr2_evt | input | 1 | Timer-2 period match strobe |
| tmr1_evt | input | 1 | Timer-1 overflow strobe |
| rx_full | input | 1 | Receive buffer holds data |
| tx_empty | input | 1 | Transmit buffer empty |
| mcu_mode | input | 1 | Microcontroller mode active |
| ccp_pwm_mode | input | 1 | Capture/compare unit in PWM mode |
| irq_en | input | 8 | Per-bit interrupt enables |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
Any wrong flag state appears on `rd_data` one cycle after the event or write that caused it, because every bit is a single register that feeds the read port directly. `irq` has no register in its path, so a masking error shows in the same cycle as the flag it concerns. A lost event or a missed clear persists across later cycles until software writes, so comparing every cycle against a model catches it even when the stimulus is random. Mirrored bits that drift from their status inputs differ from the model within one cycle.

// File: rtl/pif_pkg.sv
package pif_pkg;
  localparam int FLAG_W = 8;
  localparam int BIT_PPORT = 7;
  localparam int BIT_ADC   = 6;
  localparam int BIT_RX    = 5;
  localparam int BIT_TX    = 4;
  localparam int BIT_SSP   = 3;
  localparam int BIT_CCP   = 2;
  localparam int BIT_TMR2  = 1;
  localparam int BIT_TMR1  = 0;
  // bits that mirror a status level instead of latching events
  localparam logic [FLAG_W-1:0] MIRROR_MASK = (FLAG_W'(1) << BIT_RX) | (FLAG_W'(1) << BIT_TX);

  function automatic logic is_mirror(input int idx);
    return MIRROR_MASK[idx];
  endfunction

  // software clear request: write strobe with a zero in this bit
  function automatic logic sw_clear(input logic we, input logic data_bit);
    return we & ~data_bit;
  endfunction
endpackage

// File: rtl/pif_sticky_cell.sv
module pif_sticky_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic wclr_i,
  input  logic kill_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      q_q <= 1'b0;
    else if (kill_i) q_q <= 1'b0;
    else if (set_i)  q_q <= 1'b1;
    else if (wclr_i) q_q <= 1'b0;
  end

  assign q_o = q_q;

  // R4: a set strobe wins over a concurrent clear
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !kill_i) |=> q_o);
  // R3: without set, clear or kill, the bit holds its value
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !wclr_i && !kill_i) |=> (q_o == $past(q_o)));
  // R8: a kill forces zero
  assert_kill_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> !q_o);
endmodule

// File: rtl/pif_mirror_cell.sv
module pif_mirror_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= level_i;
  end

  assign q_o = q_q;

  // R5 / R6: the bit tracks its status level with one cycle of latency
  assert_mirror_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && $past(rst_n) |-> (q_o == $past(level_i)));
endmodule

// File: rtl/pif_irq_combine.sv
module pif_irq_combine #(
  parameter int W = 8
) (
  input  logic [W-1:0] flags_i,
  input  logic [W-1:0] en_i,
  input  logic         gie_i,
  output logic         irq_o
);
  logic [W-1:0] pend;
  assign pend  = flags_i & en_i;
  assign irq_o = gie_i & (|pend);

  // R9: no request while global enable is low
  always_comb begin
    assert_no_irq_gie_off_R9: assert (gie_i || !irq_o);
  end
endmodule

// File: rtl/pif_flagreg.sv
module pif_flagreg
  import pif_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       pport_evt,
  input  logic       adc_evt,
  input  logic       ssp_evt,
  input  logic       ccp_capture_evt,
  input  logic       ccp_compare_evt,
  input  logic       tmr2_evt,
  input  logic       tmr1_evt,
  input  logic       rx_full,
  input  logic       tx_empty,
  input  logic       mcu_mode,
  input  logic       ccp_pwm_mode,
  input  logic [7:0] irq_en,
  input  logic       gie,
  output logic       irq
);
  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] kill_vec;
  logic [FLAG_W-1:0] level_vec;
  logic [FLAG_W-1:0] flags;
  logic              ccp_hit;

  // named internal event: capture/compare strobe after mode gating
  assign ccp_hit = (ccp_capture_evt | ccp_compare_evt) & ~ccp_pwm_mode;

  always_comb begin
    set_vec            = '0;
    set_vec[BIT_PPORT] = pport_evt & mcu_mode;
    set_vec[BIT_ADC]   = adc_evt;
    set_vec[BIT_SSP]   = ssp_evt;
    set_vec[BIT_CCP]   = ccp_hit;
    set_vec[BIT_TMR2]  = tmr2_evt;
    set_vec[BIT_TMR1]  = tmr1_evt;
    kill_vec            = '0;
    kill_vec[BIT_PPORT] = ~mcu_mode;
    level_vec          = '0;
    level_vec[BIT_RX]  = rx_full;
    level_vec[BIT_TX]  = tx_empty;
  end

  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    if (is_mirror(i)) begin : g_mirror
      pif_mirror_cell u_cell (
        .clk(clk), .rst_n(rst_n), .level_i(level_vec[i]), .q_o(flags[i])
      );
    end else begin : g_sticky
      pif_sticky_cell u_cell (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec[i]),
        .wclr_i(sw_clear(wr_en, wr_data[i])), .kill_i(kill_vec[i]), .q_o(flags[i])
      );
    end
  end

  pif_irq_combine #(.W(FLAG_W)) u_irq (
    .flags_i(flags), .en_i(irq_en), .gie_i(gie), .irq_o(irq)
  );

  assign rd_data = flags;

  // R7: capture/compare flag never rises while in PWM mode
  assert_ccp_pwm_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ccp_pwm_mode && !flags[BIT_CCP]) |=> !flags[BIT_CCP]);
  // R2: an A/D strobe always lands in bit 6
  assert_adc_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_evt |=> rd_data[BIT_ADC]);
  // R6: writes never disturb the transmit mirror
  assert_tx_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && $past(rst_n) |-> (rd_data[BIT_TX] == $past(tx_empty)));
endmodule

// File: tb/pif_flagreg_tb_top.sv
module pif_flagreg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       pport_evt = 0, adc_evt = 0, ssp_evt = 0, cap_evt = 0, cmp_evt = 0;
  logic       tmr2_evt = 0, tmr1_evt = 0, rx_full = 0, tx_empty = 0;
  logic       mcu_mode = 1'b1, pwm_mode = 1'b0, gie = 1'b0;
  logic [7:0] irq_en = 8'h00;
  logic       irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] exp_q = 8'h00;

  always #4 clk = ~clk;

  pif_flagreg dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pport_evt(pport_evt), .adc_evt(adc_evt), .ssp_evt(ssp_evt),
    .ccp_capture_evt(cap_evt), .ccp_compare_evt(cmp_evt),
    .tmr2_evt(tmr2_evt), .tmr1_evt(tmr1_evt), .rx_full(rx_full), .tx_empty(tx_empty),
    .mcu_mode(mcu_mode), .ccp_pwm_mode(pwm_mode), .irq_en(irq_en), .gie(gie), .irq(irq)
  );

  // model of one clock edge, written per bit from the requirements
  function automatic logic [7:0] model_next(input logic [7:0] cur);
    logic [7:0] n;
    logic [7:0] ev;
    ev = {pport_evt, adc_evt, 1'b0, 1'b0, ssp_evt, (cap_evt | cmp_evt) & !pwm_mode, tmr2_evt, tmr1_evt};
    for (int b = 0; b < 8; b++) begin
      if (b == 5)       n[b] = rx_full;
      else if (b == 4)  n[b] = tx_empty;
      else if (ev[b])   n[b] = 1'b1;
      else if (wr_en && !wr_data[b]) n[b] = 1'b0;
      else              n[b] = cur[b];
    end
    if (!mcu_mode) n[7] = 1'b0;
    return n;
  endfunction

  function automatic logic model_irq(input logic [7:0] f);
    return gie && ((f & irq_en) != 8'h00);
  endfunction

  function automatic string req_of_bit(input int b);
    case (b)
      7: return "R8";
      5: return "R5";
      4: return "R6";
      2: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one edge: inputs are already applied; update model, sample after the edge
  task automatic tick_and_compare;
    @(posedge clk);
    exp_q = model_next(exp_q);
    #2;
    for (int b = 0; b < 8; b++) check(req_of_bit(b), 32'(rd_data[b]), 32'(exp_q[b]));
    check("R9", 32'(irq), 32'(model_irq(exp_q)));
  endtask

  task automatic quiet;
    wr_en = 0; pport_evt = 0; adc_evt = 0; ssp_evt = 0; cap_evt = 0;
    cmp_evt = 0; tmr2_evt = 0; tmr1_evt = 0;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rx_full = 1; tx_empty = 1; adc_evt = 1;
    repeat (3) @(posedge clk);
    #2;
    check("R1", 32'(rd_data), 32'h00);
    gie = 1; irq_en = 8'hFF;
    #1;
    check("R1", 32'(irq), 32'h0);
    rst_n = 1; quiet(); rx_full = 0; tx_empty = 0; exp_q = 8'h00;
    #1;
    tick_and_compare();
    check("R1", 32'(rd_data), 32'h00);

    // R2: each sticky strobe lands in its bit with all enables off
    gie = 0; irq_en = 8'h00;
    tmr1_evt = 1; tick_and_compare(); quiet();
    check("R2", 32'(rd_data), 32'h01);
    tmr2_evt = 1; tick_and_compare(); quiet();
    check("R2", 32'(rd_data), 32'h03);
    ssp_evt = 1; tick_and_compare(); quiet();
    check("R2", 32'(rd_data), 32'h0B);
    adc_evt = 1; tick_and_compare(); quiet();
    pport_evt = 1; tick_and_compare(); quiet();
    check("R2", 32'(rd_data), 32'hCB);

    // R3: writing ones changes nothing, zero clears
    wr_en = 1; wr_data = 8'hFF; tick_and_compare(); quiet();
    check("R3", 32'(rd_data), 32'hCB);
    wr_en = 1; wr_data = 8'hFE; tick_and_compare(); quiet();
    check("R3", 32'(rd_data), 32'hCA);

    // R4: set and clear together on timer-2 bit
    tmr2_evt = 1; wr_en = 1; wr_data = 8'h00; tick_and_compare(); quiet();
    check("R4", 32'(rd_data), 32'h02);

    // R5/R6: mirrors follow status, writes ignored
    rx_full = 1; tx_empty = 1; wr_en = 1; wr_data = 8'h00; tick_and_compare(); quiet();
    check("R5", 32'(rd_data[5]), 32'h1);
    check("R6", 32'(rd_data[4]), 32'h1);
    rx_full = 0; wr_en = 1; wr_data = 8'hFF; tick_and_compare(); quiet();
    check("R5", 32'(rd_data[5]), 32'h0);

    // R7: PWM mode blocks capture/compare
    pwm_mode = 1; cap_evt = 1; cmp_evt = 1; tick_and_compare(); quiet();
    check("R7", 32'(rd_data[2]), 32'h0);
    pwm_mode = 0; cmp_evt = 1; tick_and_compare(); quiet();
    check("R7", 32'(rd_data[2]), 32'h1);

    // R8: leaving microcontroller mode zeroes bit 7 and blocks its strobe
    pport_evt = 1; tick_and_compare(); quiet();
    mcu_mode = 0; tick_and_compare();
    check("R8", 32'(rd_data[7]), 32'h0);
    pport_evt = 1; tick_and_compare(); quiet();
    check("R8", 32'(rd_data[7]), 32'h0);
    mcu_mode = 1;

    // R9: masking
    gie = 1; irq_en = 8'h04; #1;
    check("R9", 32'(irq), 32'(model_irq(exp_q)));
    irq_en = 8'h80; #1;
    check("R9", 32'(irq), 32'h0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom();
      pport_evt = (r[2:0] == 0); adc_evt = (r[5:3] == 0); ssp_evt = (r[8:6] == 0);
      cap_evt = (r[11:9] == 0); cmp_evt = (r[14:12] == 0);
      tmr2_evt = (r[17:15] == 0); tmr1_evt = (r[20:18] == 0);
      rx_full = r[21]; tx_empty = r[22];
      wr_en = (r[25:23] == 0); wr_data = 8'($urandom());
      mcu_mode = (r[28:26] != 0); pwm_mode = (r[30:29] == 0); gie = r[31];
      irq_en = 8'($urandom());
      tick_and_compare();
    end
    quiet();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule